// File: doc/BRIEF.md
# Quad Channel Pulse-Width Modulator

This block produces four independent pulse-width modulated outputs from one packed control word. Each channel owns one byte of the word. A duty byte of zero holds its output low. A duty byte of all ones holds it high. Values in between give a high-time fraction equal to the byte value divided by 255.

All channels share one period counter that runs from 0 to 254 and then wraps. A channel drives high while the counter is below its duty byte. The counter steps only on clocks where the advance input is high. The host can therefore slow the PWM frequency, or freeze it, by gating that input.

A new word is captured on any clock edge where the write strobe is high. The word can be read back at any time on the read port. An asynchronous reset clears the word, so every output starts low.

Top module: `qpwm_quad`

## Requirements
- R1: While the asynchronous reset is high, the control word is zero, the read port shows 0x00000000 and every PWM output is low, even when the write strobe is held high with data 0xFFFFFFFF.
- R2: The control word changes only on a clock edge where the write strobe is high. Changing the write data without the strobe leaves the read port unchanged.
- R3: The read port always equals the stored control word. Channel k takes its duty from bits 8k+7 down to 8k, so channel 0 uses bits 7:0 and channel 3 uses bits 31:24.
- R4: A channel whose duty byte is 0x00 stays low on every cycle.
- R5: A channel whose duty byte is 0xFF stays high on every cycle.
- R6: With advance held high, the output of a channel with duty d is high for exactly 10·d clocks out of any 2550 consecutive clocks, which is d/255 of the time. For example, 0x7F gives about 50%, 0x55 about 33% and 0xAA about 67%.
- R7: The period counter steps only on clocks where advance is high. With advance low and no write, the outputs do not change. With advance high on every other clock, a channel with duty d is high for 2·d clocks out of any 510.
- R8: The period is 255 advance steps. With duty 0x01 and advance held high, the output pulses high for one clock, and its rising edges are 255 clocks apart.
- R9: After a write, each output shows its new duty within 256 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| wr_done_i | input | 1 | Write strobe; loads wr_data_i on the rising clock edge |
| wr_data_i | input | 32 | New packed control word |
| rd_data_o | output | 32 | Stored packed control word |
| adv_i | input | 1 | Enables one step of the shared period counter |
| pwm_o | output | 4 | PWM outputs, one per channel |

## Verification
The bench builds the block with its default parameters: four channels, 8-bit duties and registered outputs. With these values a full 255-step period fits many times into a 2550-clock window, so high-time counts can be compared exactly rather than against a tolerance. The bench covers both duty extremes, a mixed word that tells the byte lanes apart, the single-clock pulse of duty 1, and the counter held still or running at half rate through the advance input. The bound checker also watches the counter's range and wrap, and the one-cycle output latency of the registered variant.

// File: rtl/qpwm_pkg.sv
package qpwm_pkg;

   // Output stage variant chosen per instance
   typedef enum logic {
      QPWM_OUT_COMB = 1'b0,
      QPWM_OUT_REG  = 1'b1
   } qpwm_out_e;

   localparam int QPWM_NUM_CH_DEF = 4;
   localparam int QPWM_DUTY_W_DEF = 8;

   // Largest count value: one step short of all ones, so all-ones duty is full on
   function automatic int qpwm_cnt_max(input int duty_w);
      return (2 ** duty_w) - 2;
   endfunction

endpackage

// File: rtl/qpwm_duty_reg.sv
module qpwm_duty_reg #(
   parameter int DATA_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              ld_i,
   input  logic [DATA_W-1:0] d_i,
   output logic [DATA_W-1:0] q_o
);

   if (DATA_W < 1) begin : g_bad_w
      $error("qpwm_duty_reg: DATA_W must be positive");
   end

   logic [DATA_W-1:0] word_q;

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         word_q <= '0;
      end else if (ld_i) begin
         word_q <= d_i;
      end
   end

   assign q_o = word_q;

endmodule

// File: rtl/qpwm_period_ctr.sv
module qpwm_period_ctr #(
   parameter int CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             adv_i,
   output logic [CNT_W-1:0] cnt_o
);

   import qpwm_pkg::*;

   localparam int             CNT_MAX_I = qpwm_cnt_max(CNT_W);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CNT_MAX_I);

   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_w
      $error("qpwm_period_ctr: CNT_W must lie in 2..16");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             at_top;

   assign at_top = (cnt_q == CNT_MAX);

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         cnt_q <= '0;
      end else if (adv_i) begin
         cnt_q <= at_top ? '0 : cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/qpwm_chan.sv
module qpwm_chan #(
   parameter int                  DUTY_W   = 8,
   parameter qpwm_pkg::qpwm_out_e OUT_MODE = qpwm_pkg::QPWM_OUT_REG
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [DUTY_W-1:0] cnt_i,
   input  logic [DUTY_W-1:0] duty_i,
   output logic              pwm_o
);

   import qpwm_pkg::*;

   logic on_now;

   // Counter never reaches all ones, so all-ones duty is on for the whole period
   assign on_now = (cnt_i < duty_i);

   if (OUT_MODE == QPWM_OUT_REG) begin : g_reg
      logic pwm_q;
      always_ff @(posedge clk_i or posedge rst_i) begin
         if (rst_i) begin
            pwm_q <= 1'b0;
         end else begin
            pwm_q <= on_now;
         end
      end
      assign pwm_o = pwm_q;
   end else begin : g_comb
      // Reset clears duty, which forces on_now low; clock unused here
      logic unused_in;
      assign unused_in = clk_i ^ rst_i;
      assign pwm_o     = on_now & ~rst_i;
   end

endmodule

// File: rtl/qpwm_quad.sv
module qpwm_quad #(
   parameter int                  NUM_CH   = qpwm_pkg::QPWM_NUM_CH_DEF,
   parameter int                  DUTY_W   = qpwm_pkg::QPWM_DUTY_W_DEF,
   parameter qpwm_pkg::qpwm_out_e OUT_MODE = qpwm_pkg::QPWM_OUT_REG,
   localparam int                 DATA_W   = NUM_CH * DUTY_W
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              wr_done_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic              adv_i,
   output logic [NUM_CH-1:0] pwm_o
);

   if (NUM_CH < 1 || NUM_CH > 32) begin : g_bad_ch
      $error("qpwm_quad: NUM_CH must lie in 1..32");
   end
   if (DUTY_W < 2 || DUTY_W > 16) begin : g_bad_dw
      $error("qpwm_quad: DUTY_W must lie in 2..16");
   end

   logic [DATA_W-1:0] ctrl_word;
   logic [DUTY_W-1:0] period_cnt;

   qpwm_duty_reg #(
      .DATA_W (DATA_W)
   ) i_duty_reg (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .ld_i  (wr_done_i),
      .d_i   (wr_data_i),
      .q_o   (ctrl_word)
   );

   qpwm_period_ctr #(
      .CNT_W (DUTY_W)
   ) i_period_ctr (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .adv_i (adv_i),
      .cnt_o (period_cnt)
   );

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      qpwm_chan #(
         .DUTY_W   (DUTY_W),
         .OUT_MODE (OUT_MODE)
      ) i_chan (
         .clk_i  (clk_i),
         .rst_i  (rst_i),
         .cnt_i  (period_cnt),
         .duty_i (ctrl_word[k*DUTY_W +: DUTY_W]),
         .pwm_o  (pwm_o[k])
      );
   end

   assign rd_data_o = ctrl_word;

endmodule

// File: rtl/qpwm_quad_chk.sv
module qpwm_quad_chk #(
   parameter int                  NUM_CH   = 4,
   parameter int                  DUTY_W   = 8,
   parameter qpwm_pkg::qpwm_out_e OUT_MODE = qpwm_pkg::QPWM_OUT_REG,
   localparam int                 DATA_W   = NUM_CH * DUTY_W
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic              wr_done_i,
   input logic [DATA_W-1:0] wr_data_i,
   input logic [DATA_W-1:0] rd_data_o,
   input logic              adv_i,
   input logic [NUM_CH-1:0] pwm_o,
   input logic [DUTY_W-1:0] cnt_i
);

   import qpwm_pkg::*;

   localparam logic [DUTY_W-1:0] CMAX = DUTY_W'(qpwm_cnt_max(DUTY_W));

   // R1: held reset keeps word and outputs clear
   p_reset_clear_r1: assert property (@(posedge clk_i)
      (rst_i && $past(rst_i)) |-> (rd_data_o == '0 && pwm_o == '0));

   // R2: no strobe, word unchanged
   p_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      !wr_done_i |=> $stable(rd_data_o));

   // R3: strobe loads the presented data
   p_load_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      wr_done_i |=> (rd_data_o == $past(wr_data_i)));

   // R8: counter range and wrap
   p_ctr_range_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      cnt_i <= CMAX);
   p_ctr_wrap_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      (adv_i && cnt_i == CMAX) |=> (cnt_i == '0));

   // R7: counter frozen without advance
   p_ctr_freeze_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      !adv_i |=> $stable(cnt_i));

   if (OUT_MODE == QPWM_OUT_REG) begin : g_reg_chk
      p_out_freeze_r7: assert property (@(posedge clk_i) disable iff (rst_i)
         (!adv_i && !wr_done_i) |=> ##1 $stable(pwm_o));
      for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
         p_zero_low_r4: assert property (@(posedge clk_i) disable iff (rst_i)
            (rd_data_o[k*DUTY_W +: DUTY_W] == '0) |=> !pwm_o[k]);
         p_full_high_r5: assert property (@(posedge clk_i) disable iff (rst_i)
            (&rd_data_o[k*DUTY_W +: DUTY_W]) |=> pwm_o[k]);
      end
   end else begin : g_comb_chk
      p_out_freeze_r7: assert property (@(posedge clk_i) disable iff (rst_i)
         (!adv_i && !wr_done_i) |=> $stable(pwm_o));
      for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
         p_zero_low_r4: assert property (@(posedge clk_i) disable iff (rst_i)
            (rd_data_o[k*DUTY_W +: DUTY_W] == '0) |-> !pwm_o[k]);
         p_full_high_r5: assert property (@(posedge clk_i) disable iff (rst_i)
            (&rd_data_o[k*DUTY_W +: DUTY_W]) |-> pwm_o[k]);
      end
   end

endmodule

bind qpwm_quad qpwm_quad_chk #(
   .NUM_CH   (NUM_CH),
   .DUTY_W   (DUTY_W),
   .OUT_MODE (OUT_MODE)
) i_qpwm_quad_chk (
   .clk_i     (clk_i),
   .rst_i     (rst_i),
   .wr_done_i (wr_done_i),
   .wr_data_i (wr_data_i),
   .rd_data_o (rd_data_o),
   .adv_i     (adv_i),
   .pwm_o     (pwm_o),
   .cnt_i     (period_cnt)
);

// File: tb/test_qpwm_quad.sv
`timescale 1ns/1ps
module test_qpwm_quad;

   localparam int NCH = 4;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_done = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        adv = 1'b1;
   logic [3:0]  pwm;

   int n_cmp = 0;
   int n_bad = 0;
   int hi[NCH];

   always #10 clk = ~clk;   // 50 MHz

   qpwm_quad i_qpwm_quad (
      .clk_i     (clk),
      .rst_i     (rst),
      .wr_done_i (wr_done),
      .wr_data_i (wr_data),
      .rd_data_o (rd_data),
      .adv_i     (adv),
      .pwm_o     (pwm)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic write_word(input logic [31:0] w);
      @(negedge clk);
      wr_data = w;
      wr_done = 1'b1;
      @(negedge clk);
      wr_done = 1'b0;
   endtask

   // Count high samples per channel over n clocks, optionally toggling advance
   task automatic measure(input int n, input bit half_rate);
      for (int c = 0; c < NCH; c++) hi[c] = 0;
      for (int s = 0; s < n; s++) begin
         @(negedge clk);
         if (half_rate) adv = ~adv;
         for (int c = 0; c < NCH; c++) if (pwm[c]) hi[c]++;
      end
   endtask

   task automatic t_reset;
      // R1: reset with a write attempt of all ones
      @(negedge clk);
      rst = 1'b1;
      wr_data = 32'hFFFF_FFFF;
      wr_done = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 read during reset", rd_data, 32'h0);
      check("R1 pwm during reset", {28'h0, pwm}, 32'h0);
      wr_done = 1'b0;
      rst = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 read after reset", rd_data, 32'h0);
      check("R1 pwm after reset", {28'h0, pwm}, 32'h0);
   endtask

   task automatic t_hold;
      write_word(32'h1234_5678);
      check("R3 read back", rd_data, 32'h1234_5678);
      wr_data = 32'hDEAD_BEEF;
      repeat (5) @(negedge clk);
      check("R2 data without strobe ignored", rd_data, 32'h1234_5678);
   endtask

   task automatic t_duty(input logic [31:0] w);
      write_word(w);
      check("R3 read back", rd_data, w);
      repeat (256) @(negedge clk);
      measure(2550, 1'b0);
      for (int c = 0; c < NCH; c++) begin
         int d;
         d = int'(w[c*8 +: 8]);
         if (d == 0)
            check("R4 duty zero stays low", hi[c], 0);
         else if (d == 255)
            check("R5 duty full stays high", hi[c], 2550);
         else
            check("R6 high clocks in 2550", hi[c], 10 * d);
      end
   endtask

   task automatic t_settle;
      write_word(32'h0000_0000);
      repeat (300) @(negedge clk);
      write_word(32'hFFFF_FFFF);
      repeat (255) @(negedge clk);
      check("R9 settled within 256 clocks", {28'h0, pwm}, 32'hF);
   endtask

   task automatic t_adv;
      logic [3:0] snap;
      int changes;
      write_word(32'hC080_4010);
      repeat (100) @(negedge clk);
      adv = 1'b0;
      repeat (2) @(negedge clk);
      snap = pwm;
      changes = 0;
      for (int s = 0; s < 300; s++) begin
         @(negedge clk);
         if (pwm !== snap) changes++;
      end
      check("R7 outputs frozen without advance", changes, 0);
      check("R7 word kept while frozen", rd_data, 32'hC080_4010);
      measure(510, 1'b1);
      check("R7 half rate ch0", hi[0], 2 * 32'h10);
      check("R7 half rate ch1", hi[1], 2 * 32'h40);
      check("R7 half rate ch2", hi[2], 2 * 32'h80);
      check("R7 half rate ch3", hi[3], 2 * 32'hC0);
      adv = 1'b1;
   endtask

   task automatic t_period;
      int first, second, width, s;
      logic prev;
      write_word(32'h0000_0001);
      repeat (256) @(negedge clk);
      first = -1; second = -1; width = 0;
      prev = pwm[0];
      for (s = 0; s < 700 && second < 0; s++) begin
         @(negedge clk);
         if (pwm[0] && !prev) begin
            if (first < 0) first = s; else second = s;
         end
         if (first >= 0 && second < 0 && pwm[0]) width++;
         prev = pwm[0];
      end
      check("R8 rise-to-rise period", second - first, 255);
      check("R8 pulse width for duty 1", width, 1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 initial read", rd_data, 32'h0);
      check("R1 initial pwm", {28'h0, pwm}, 32'h0);
      t_hold();
      t_duty(32'h0000_0000);
      t_duty(32'hFFFF_FFFF);
      t_duty(32'h7F7F_7F7F);
      t_duty(32'hFFAA_5500);
      t_duty(32'h01FE_8040);
      t_settle();
      t_adv();
      t_period();
      t_reset();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule